// File: doc/BRIEF.md
# Dual-Mode PWM Timer

A single 16-bit timer channel that turns a count-enable strobe into a pulse-width-modulated output. The channel has two waveform modes. In the fixed-period mode the counter runs freely. It passes from the all-ones value back to zero, so one period is always 2^16 count ticks. The output rises on the tick where the counter equals the first compare value and falls on the rollover tick. In the variable-period mode the counter climbs to the active compare value and restarts at zero. Each such match inverts the output and hands the match duty to the other compare value. The first compare value therefore sets the low phase and the second sets the high phase. Neither mode ever stops by itself.

The mode is held in a three-state machine. FIXED covers the whole fixed-period mode. VAR_A is the variable-period phase that uses the first compare value, and VAR_B is the phase that uses the second. The transitions are:
- ENTER_VAR: FIXED to VAR_A when the mode select is 1.
- ENTER_FIXED: VAR_A or VAR_B to FIXED when the mode select is 0.
- SWAP_AB: VAR_A to VAR_B on a ticked match.
- SWAP_BA: VAR_B to VAR_A on a ticked match.

ENTER_VAR and ENTER_FIXED also clear the counter and the output. Compare values come straight from the input ports and are not double-buffered.

Top module: `pwm_dual_timer`

## Requirements
- R1: After reset `count_o` is 0, `pwm_o` is 0 and `cmp_sel_o` is 0 (the first compare value is active).
- R2: The counter changes only in a cycle where `tick_i` is 1. With `tick_i` at 0 and no mode change, `count_o`, `pwm_o` and `cmp_sel_o` hold.
- R3: In fixed-period mode (`var_mode_i` = 0), each tick adds one to the counter. A tick at 0xFFFF gives 0, so a period is 65,536 ticks.
- R4: In fixed-period mode, a tick taken while the counter equals `cmp_a_i` (and is not 0xFFFF) drives `pwm_o` to 1 in the next cycle. `cmp_b_i` has no effect in this mode.
- R5: In fixed-period mode, a tick taken at 0xFFFF drives `pwm_o` to 0 in the next cycle. This rollover clear wins over a compare match in the same tick, so `cmp_a_i` = 0xFFFF keeps the output low.
- R6: In fixed-period mode with `cmp_a_i` = 0, the output is high for 65,535 of every 65,536 ticks.
- R7: In variable-period mode (`var_mode_i` = 1), a tick taken while the counter equals the active compare value returns the counter to 0, inverts `pwm_o` and inverts `cmp_sel_o`. `cmp_sel_o` = 0 selects `cmp_a_i` and `cmp_sel_o` = 1 selects `cmp_b_i`. Any other tick adds one.
- R8: In variable-period mode, started from a mode change, the output is low for `cmp_a_i`+1 ticks and then high for `cmp_b_i`+1 ticks. One period is (`cmp_a_i`+1)+(`cmp_b_i`+1) ticks.
- R9: A change of `var_mode_i` sets `count_o` to 0, `pwm_o` to 0 and `cmp_sel_o` to 0 in the next cycle. This takes priority over a tick in the same cycle.
- R10: A new compare value takes effect at the very next tick's comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-enable strobe, one count per high cycle |
| var_mode_i | input | 1 | 0 = fixed-period mode, 1 = variable-period mode |
| cmp_a_i | input | 16 | First compare value |
| cmp_b_i | input | 16 | Second compare value (variable-period mode only) |
| pwm_o | output | 1 | PWM output |
| count_o | output | 16 | Current counter value |
| cmp_sel_o | output | 1 | Active compare value, 0 = first, 1 = second |

## Verification
Two pairs of events can fall in the same clock cycle. The first pair is the fixed-mode rollover clear and a compare set. The bench provokes this by holding `cmp_a_i` at 0xFFFF through a wrap; the output must stay low across the rollover and afterwards. The second pair is a mode change and a ticked count. The bench flips `var_mode_i` while strobing `tick_i`, mid-phase and with the output high; the next cycle must show a zero counter, a low output and the first compare value selected. A behavioural model in the bench is stepped on every clock and compared against all three outputs. It also covers compare values rewritten while the counter runs, and irregular tick patterns.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    typedef enum logic [1:0] {
        ST_FIXED = 2'd0,
        ST_VAR_A = 2'd1,
        ST_VAR_B = 2'd2
    } pwm_state_e;
endpackage

// File: rtl/pwm_cnt.sv
module pwm_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         tick_i,
    input  logic         reload_i,
    output logic [W-1:0] cnt_o,
    output logic         at_max_o
);
    localparam logic [W-1:0] MAX_V = '1;
    localparam logic [W-1:0] ONE_V = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (reload_i) cnt_q <= '0;
            else          cnt_q <= cnt_q + ONE_V;
        end
    end

    assign cnt_o    = cnt_q;
    assign at_max_o = (cnt_q == MAX_V);

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(cnt_q));
    // R3
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_i && !reload_i && at_max_o) |=> (cnt_q == '0));
    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_i && !reload_i) |=> (cnt_q == $past(cnt_q) + ONE_V));
    // R9
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_match.sv
module pwm_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] cmp_a_i,
    input  logic [W-1:0] cmp_b_i,
    input  logic         sel_b_i,
    output logic         hit_fixed_o,
    output logic         hit_var_o
);
    logic [W-1:0] active_cmp;

    always_comb begin
        active_cmp  = sel_b_i ? cmp_b_i : cmp_a_i;
        hit_fixed_o = (cnt_i == cmp_a_i);
        hit_var_o   = (cnt_i == active_cmp);
    end
endmodule

// File: rtl/pwm_mode_fsm.sv
module pwm_mode_fsm
    import pwm_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic var_mode_i,
    input  logic tick_i,
    input  logic hit_var_i,
    output logic clr_o,
    output logic swap_o,
    output logic is_var_o,
    output logic sel_b_o
);
    pwm_state_e state_q, state_d;

    // next-state and transition naming
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FIXED: begin
                if (var_mode_i) state_d = ST_VAR_A;                 // ENTER_VAR
            end
            ST_VAR_A: begin
                if (!var_mode_i)               state_d = ST_FIXED;  // ENTER_FIXED
                else if (tick_i && hit_var_i)  state_d = ST_VAR_B;  // SWAP_AB
            end
            ST_VAR_B: begin
                if (!var_mode_i)               state_d = ST_FIXED;  // ENTER_FIXED
                else if (tick_i && hit_var_i)  state_d = ST_VAR_A;  // SWAP_BA
            end
            default: state_d = ST_FIXED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FIXED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        is_var_o = (state_q != ST_FIXED);
        sel_b_o  = (state_q == ST_VAR_B);
        clr_o    = (var_mode_i != is_var_o);
        swap_o   = !clr_o && is_var_o && tick_i && hit_var_i;
    end

    // R9
    fsm_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> (state_q == ST_FIXED || state_q == ST_VAR_A));
    // R7
    fsm_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_o |=> (sel_b_o != $past(sel_b_o)));
    // R2
    fsm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_o) |=> $stable(state_q));
    // R1
    fsm_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({state_q == ST_FIXED, state_q == ST_VAR_A, state_q == ST_VAR_B}));
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic tick_i,
    input  logic is_var_i,
    input  logic swap_i,
    input  logic hit_fixed_i,
    input  logic at_max_i,
    output logic pwm_o
);
    logic pwm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else if (clr_i) begin
            pwm_q <= 1'b0;
        end else if (tick_i) begin
            if (is_var_i) begin
                if (swap_i) pwm_q <= ~pwm_q;
            end else if (at_max_i) begin
                pwm_q <= 1'b0;
            end else if (hit_fixed_i) begin
                pwm_q <= 1'b1;
            end
        end
    end

    assign pwm_o = pwm_q;

    // R4
    out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_i && !is_var_i && hit_fixed_i && !at_max_i) |=> pwm_q);
    // R5
    out_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_i && !is_var_i && at_max_i) |=> !pwm_q);
    // R7
    out_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_i |=> (pwm_q != $past(pwm_q)));
    // R9
    out_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !pwm_q);
    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(pwm_q));
endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             var_mode_i,
    input  logic [CNT_W-1:0] cmp_a_i,
    input  logic [CNT_W-1:0] cmp_b_i,
    output logic             pwm_o,
    output logic [CNT_W-1:0] count_o,
    output logic             cmp_sel_o
);
    logic             clr, swap, is_var, sel_b;
    logic             hit_fixed, hit_var, at_max;
    logic [CNT_W-1:0] cnt;

    pwm_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .var_mode_i (var_mode_i),
        .tick_i     (tick_i),
        .hit_var_i  (hit_var),
        .clr_o      (clr),
        .swap_o     (swap),
        .is_var_o   (is_var),
        .sel_b_o    (sel_b)
    );

    pwm_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .tick_i   (tick_i),
        .reload_i (swap),
        .cnt_o    (cnt),
        .at_max_o (at_max)
    );

    pwm_match #(.W(CNT_W)) u_match (
        .cnt_i       (cnt),
        .cmp_a_i     (cmp_a_i),
        .cmp_b_i     (cmp_b_i),
        .sel_b_i     (sel_b),
        .hit_fixed_o (hit_fixed),
        .hit_var_o   (hit_var)
    );

    pwm_out_stage u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr),
        .tick_i      (tick_i),
        .is_var_i    (is_var),
        .swap_i      (swap),
        .hit_fixed_i (hit_fixed),
        .at_max_i    (at_max),
        .pwm_o       (pwm_o)
    );

    assign count_o   = cnt;
    assign cmp_sel_o = sel_b;

    // R7
    top_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && var_mode_i && is_var && hit_var) |=> (count_o == '0));
    // R8
    top_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_var |-> (pwm_o == cmp_sel_o));
endmodule

// File: tb/sim_pwm_dual_timer.sv
module sim_pwm_dual_timer;
    localparam int CLK_PERIOD = 10;
    localparam int MAXC = 65535;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        var_mode_i = 1'b0;
    logic [15:0] cmp_a_i = '0;
    logic [15:0] cmp_b_i = '0;
    logic        pwm_o;
    logic [15:0] count_o;
    logic        cmp_sel_o;

    int  checks = 0;
    int  fails  = 0;
    int  m_cnt  = 0;
    bit  m_pwm  = 0;
    bit  m_sel  = 0;
    bit  m_var  = 0;
    bit  done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_dual_timer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .var_mode_i (var_mode_i),
        .cmp_a_i    (cmp_a_i),
        .cmp_b_i    (cmp_b_i),
        .pwm_o      (pwm_o),
        .count_o    (count_o),
        .cmp_sel_o  (cmp_sel_o)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference, one clock edge
    task automatic model_edge();
        int act;
        if (var_mode_i != m_var) begin
            m_var = var_mode_i; m_cnt = 0; m_pwm = 0; m_sel = 0;
        end else if (tick_i) begin
            if (!m_var) begin
                if (m_cnt == MAXC)            m_pwm = 0;
                else if (m_cnt == int'(cmp_a_i)) m_pwm = 1;
                m_cnt = (m_cnt + 1) % 65536;
            end else begin
                act = m_sel ? int'(cmp_b_i) : int'(cmp_a_i);
                if (m_cnt == act) begin
                    m_cnt = 0; m_pwm = !m_pwm; m_sel = !m_sel;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
        end
    endtask

    task automatic step(bit en, string tag);
        tick_i = en;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        checks++;
        if (int'(count_o) != m_cnt || pwm_o != m_pwm || cmp_sel_o != m_sel) begin
            fails++;
            $display("FAIL %s actual cnt=%0d pwm=%0d sel=%0d expected cnt=%0d pwm=%0d sel=%0d",
                     tag, count_o, pwm_o, cmp_sel_o, m_cnt, m_pwm, m_sel);
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int highs;
        int lows;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(count_o == 0, "R1 count", count_o, 0);
        chk(pwm_o == 0, "R1 pwm", pwm_o, 0);
        chk(cmp_sel_o == 0, "R1 sel", cmp_sel_o, 0);

        // R2 idle holds, ticks advance
        cmp_a_i = 16'd1000;
        for (int i = 0; i < 5; i++)  step(1'b0, "R2 idle");
        for (int i = 0; i < 20; i++) step(1'b1, "R3 count");
        for (int i = 0; i < 3; i++)  step(1'b0, "R2 idle");
        chk(count_o == 20, "R2 held count", count_o, 20);

        // R8 variable period with A=3, B=5
        var_mode_i = 1'b1; cmp_a_i = 16'd3; cmp_b_i = 16'd5;
        step(1'b1, "R9 enter var");
        chk(count_o == 0, "R9 enter var count", count_o, 0);
        highs = 0; lows = 0;
        for (int i = 0; i < 10; i++) begin
            step(1'b1, "R8 period");
            if (pwm_o) highs++; else lows++;
        end
        chk(highs == 6, "R8 high ticks", highs, 6);
        chk(lows == 4, "R8 low ticks", lows, 4);
        chk(count_o == 0 && cmp_sel_o == 0, "R8 period end", count_o, 0);

        // R7 R10 irregular ticks, compare values rewritten while running
        for (int i = 0; i < 2000; i++) begin
            if (i % 20 == 0) begin
                cmp_a_i = 16'($urandom_range(0, 7));
                cmp_b_i = 16'($urandom_range(0, 7));
            end
            step(1'($urandom_range(0, 3) != 0), "R7 var run");
        end

        // R9 mode change while ticking, output high
        cmp_a_i = 16'd2; cmp_b_i = 16'd9;
        var_mode_i = 1'b0; step(1'b0, "R9 to fixed");
        var_mode_i = 1'b1; step(1'b0, "R9 to var");
        for (int i = 0; i < 5; i++) step(1'b1, "R7 var");
        chk(pwm_o == 1 && count_o == 2, "R7 mid phase", count_o, 2);
        var_mode_i = 1'b0;
        step(1'b1, "R9 collide");
        chk(count_o == 0, "R9 collide count", count_o, 0);
        chk(pwm_o == 0, "R9 collide pwm", pwm_o, 0);
        chk(cmp_sel_o == 0, "R9 collide sel", cmp_sel_o, 0);

        // R6 compare 0, full period
        cmp_a_i = 16'd0; highs = 0;
        for (int i = 0; i < 65536; i++) begin
            cmp_b_i = 16'($urandom_range(0, 65535));
            step(1'b1, "R6 duty");
            if (pwm_o) highs++;
        end
        chk(highs == 65535, "R6 high ticks", highs, 65535);
        chk(count_o == 0, "R3 wrap to zero", count_o, 0);

        // R10 R4 R5: rewrite compare mid-run, then collide at 0xFFFF
        cmp_a_i = 16'h0FFF;
        for (int i = 0; i < 16'h80; i++) step(1'b1, "R4 fixed");
        cmp_a_i = 16'h0100;
        for (int i = 16'h80; i < 16'h200; i++) step(1'b1, "R10 rewrite");
        chk(pwm_o == 1, "R10 new compare used", pwm_o, 1);
        cmp_a_i = 16'hFFFF;
        for (int i = 16'h200; i < 65536; i++) step(1'b1, "R5 run");
        chk(count_o == 0 && pwm_o == 0, "R5 rollover clears", pwm_o, 0);
        for (int i = 0; i < 50; i++) step(1'b1, "R5 low after");
        chk(pwm_o == 0, "R5 match at max stays low", pwm_o, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule